// File: doc/BRIEF.md
# Serial Flash Write-Protection Guard

This block is the command gate inside a serial NOR flash slave. A serial front end hands it one decoded frame per chip-select release. The frame carries the opcode, the number of bits clocked while select was low, an address and the first status data byte. The guard holds the write-enable latch, four block-protect bits, the status-register write-disable bit and the deep-power-down state. It answers each frame with exactly one accept or reject strobe, and the rest of the device acts only on accepted frames.

A frame is carried out only when it passes every gate that applies to it:
- a power-up lockout timer,
- a byte-boundary length check,
- the write-enable latch,
- a filter that admits a single opcode while powered down,
- a hardware lock on status writes, driven by a write-protect pin and lifted in quad I/O mode,
- an address map that marks an upper fraction of the array read-only.

Top module: `flash_wr_guard`

## Requirements
- R1: After reset, wel, bp, srwd, deep_pd, ready, cmd_accept and cmd_reject are all 0.
- R2: Until PUW_CYCLES clocks after reset release, ready is 0 and every modifying command (WRSR 0x01, PP 0x02, SE 0x20, BE 0xD8, CE 0x60/0xC7) is rejected; after that, ready is 1.
- R3: One clock after a cycle with cmd_valid high, exactly one of cmd_accept and cmd_reject is high. Neither is high in any other cycle.
- R4: A frame whose cmd_bits is zero, or is not a multiple of 8, is rejected and changes no state.
- R5: An accepted WREN (0x06) sets wel, and an accepted WRDI (0x04) clears it.
- R6: A modifying command is rejected while wel is 0. When it is accepted, wel clears. When it is rejected, wel keeps its value.
- R7: An accepted WRSR loads srwd from cmd_data[7] and bp from cmd_data[5:2].
- R8: WRSR is rejected when srwd is 1, wp_n is 0 and quad_mode is 0. With quad_mode at 1, the wp_n lock does not apply.
- R9: An accepted DP (0xB9) sets deep_pd. While deep_pd is 1, every frame except 0xAB is rejected, and an accepted 0xAB clears deep_pd.
- R10: PP, SE and BE are rejected when cmd_addr is protected. With bp = n != 0 and k = 15 - n, the top 2^(ADDR_W-k) bytes are protected, so bp = 15 protects the whole array.
- R11: CE is rejected whenever bp is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe: a frame ended with chip-select release |
| cmd_op | input | 8 | Opcode of the frame |
| cmd_bits | input | CNT_W | Bits clocked during the frame |
| cmd_addr | input | ADDR_W | Byte address for program and erase |
| cmd_data | input | 8 | First data byte (status write value) |
| wp_n | input | 1 | Write-protect pin, active low |
| quad_mode | input | 1 | Quad I/O mode active |
| cmd_accept | output | 1 | Frame may be executed |
| cmd_reject | output | 1 | Frame is dropped |
| wel | output | 1 | Write-enable latch |
| bp | output | 4 | Block-protect level |
| srwd | output | 1 | Status write-disable bit |
| deep_pd | output | 1 | Deep power-down state |
| ready | output | 1 | Power-up lockout has expired |

## Verification
Every internal state bit is exported, so a wrong latch, protect level or power-down flag shows on its own port in the cycle after the frame that set it. A wrong gate decision shows on the accept and reject strobes one clock after cmd_valid. A frame that was wrongly accepted also shows as a cleared wel or a changed bp. A wrongly kept state shows on a later frame as an accept where a reject was due. The bench reads every output after each frame, so a fault is found within one command.

// File: rtl/fwg_pkg.sv
// Package: opcodes and widths shared by the write guard.
// Assumes one opcode byte per frame, as decoded by the serial front end.
package fwg_pkg;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_PP   = 8'h02;
    localparam logic [7:0] OP_SE   = 8'h20;
    localparam logic [7:0] OP_BE   = 8'hD8;
    localparam logic [7:0] OP_CE1  = 8'h60;
    localparam logic [7:0] OP_CE2  = 8'hC7;
    localparam logic [7:0] OP_DP   = 8'hB9;
    localparam logic [7:0] OP_RDP  = 8'hAB;
    localparam int BP_W = 4;

    typedef enum logic [2:0] {
        CL_OTHER, CL_WREN, CL_WRDI, CL_WRSR, CL_PROG, CL_CE, CL_DP, CL_RDP
    } op_class_t;
endpackage

// File: rtl/fwg_lockout.sv
// Power-up lockout timer: ready rises PUW_CYCLES clocks after reset release.
// Assumes PUW_CYCLES >= 1.
module fwg_lockout #(
    parameter int PUW_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);
    localparam int CW = $clog2(PUW_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(PUW_CYCLES);

    logic [CW-1:0] cnt;

    // Count up from reset and hold at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (cnt != LIMIT) cnt <= cnt + 1'b1;
    end

    assign ready = (cnt == LIMIT);

    assert_lock_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ready) |-> ready);
endmodule

// File: rtl/fwg_prot_map.sv
// Protect map: level n (1..15) marks the top 1/2^(15-n) of the array read-only.
// Assumes ADDR_W >= 14, so every level maps to a whole region.
module fwg_prot_map #(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [fwg_pkg::BP_W-1:0] level,
    output logic                   prot
);
    localparam logic [ADDR_W-1:0] ONES = '1;

    logic [3:0]        k;
    logic [ADDR_W-1:0] mask;

    // Mask of the top k address bits; the address is protected when all are set.
    always_comb begin
        k    = 4'd15 - level;
        mask = ~(ONES >> k);
        prot = (level != '0) && ((addr & mask) == mask);
    end
endmodule

// File: rtl/fwg_gate.sv
// Gate decision: classifies the opcode and decides accept or reject.
// Pure combinational logic; state comes from the top-level registers.
module fwg_gate #(
    parameter int CNT_W = 16
) (
    input  logic [7:0]               op,
    input  logic [CNT_W-1:0]         bits,
    input  logic                     wel,
    input  logic [fwg_pkg::BP_W-1:0] bp,
    input  logic                     srwd,
    input  logic                     wp_n,
    input  logic                     quad,
    input  logic                     dpd,
    input  logic                     ready,
    input  logic                     prot,
    output fwg_pkg::op_class_t       cls,
    output logic                     ok
);
    import fwg_pkg::*;

    logic len_ok, modifying, spec_ok;

    // Map the opcode to its class.
    always_comb begin
        unique case (op)
            OP_WREN:         cls = CL_WREN;
            OP_WRDI:         cls = CL_WRDI;
            OP_WRSR:         cls = CL_WRSR;
            OP_PP, OP_SE, OP_BE: cls = CL_PROG;
            OP_CE1, OP_CE2:  cls = CL_CE;
            OP_DP:           cls = CL_DP;
            OP_RDP:          cls = CL_RDP;
            default:         cls = CL_OTHER;
        endcase
    end

    // Combine length, power-down, lockout, latch and protection gates.
    always_comb begin
        len_ok    = (bits != '0) && (bits[2:0] == 3'd0);
        modifying = (cls == CL_WRSR) || (cls == CL_PROG) || (cls == CL_CE);
        unique case (cls)
            CL_WRSR: spec_ok = !(srwd && !wp_n && !quad);
            CL_PROG: spec_ok = !prot;
            CL_CE:   spec_ok = (bp == '0);
            default: spec_ok = 1'b1;
        endcase
        if (!len_ok)         ok = 1'b0;
        else if (dpd)        ok = (cls == CL_RDP);
        else if (modifying)  ok = ready && wel && spec_ok;
        else                 ok = 1'b1;
    end
endmodule

// File: rtl/flash_wr_guard.sv
// Write-protection guard: registers the gate decision and owns the
// latch, protect level, write-disable bit and power-down state.
// Assumes cmd_valid is a one-cycle strobe at chip-select release.
module flash_wr_guard #(
    parameter int ADDR_W     = 24,
    parameter int CNT_W      = 16,
    parameter int PUW_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [CNT_W-1:0]  cmd_bits,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              wp_n,
    input  logic              quad_mode,
    output logic              cmd_accept,
    output logic              cmd_reject,
    output logic              wel,
    output logic [3:0]        bp,
    output logic              srwd,
    output logic              deep_pd,
    output logic              ready
);
    import fwg_pkg::*;

    op_class_t cls;
    logic      ok, prot;

    fwg_lockout #(.PUW_CYCLES(PUW_CYCLES)) u_lock (
        .clk(clk), .rst_n(rst_n), .ready(ready));

    fwg_prot_map #(.ADDR_W(ADDR_W)) u_map (
        .addr(cmd_addr), .level(bp), .prot(prot));

    fwg_gate #(.CNT_W(CNT_W)) u_gate (
        .op(cmd_op), .bits(cmd_bits), .wel(wel), .bp(bp), .srwd(srwd),
        .wp_n(wp_n), .quad(quad_mode), .dpd(deep_pd), .ready(ready),
        .prot(prot), .cls(cls), .ok(ok));

    // Register the outcome strobes, one per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_accept <= 1'b0;
            cmd_reject <= 1'b0;
        end else begin
            cmd_accept <= cmd_valid && ok;
            cmd_reject <= cmd_valid && !ok;
        end
    end

    // Update protection state on accepted frames only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel     <= 1'b0;
            bp      <= '0;
            srwd    <= 1'b0;
            deep_pd <= 1'b0;
        end else if (cmd_valid && ok) begin
            unique case (cls)
                CL_WREN: wel <= 1'b1;
                CL_WRDI: wel <= 1'b0;
                CL_WRSR: begin
                    wel  <= 1'b0;
                    srwd <= cmd_data[7];
                    bp   <= cmd_data[5:2];
                end
                CL_PROG, CL_CE: wel <= 1'b0;
                CL_DP:   deep_pd <= 1'b1;
                CL_RDP:  deep_pd <= 1'b0;
                default: ;
            endcase
        end
    end

    assert_one_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_valid) |-> (cmd_accept ^ cmd_reject));
    assert_no_stray_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cmd_valid) |-> !(cmd_accept || cmd_reject));
    assert_frame_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_accept |-> ($past(cmd_bits[2:0]) == 3'd0 && $past(cmd_bits) != '0));
    assert_wel_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> ($past(cmd_valid) && $past(cmd_op) == OP_WREN));
    assert_bp_needs_wel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bp) |-> $past(wel));
    assert_lockout_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_accept && $past(cmd_op) == OP_WRSR) |-> $past(ready));
    assert_dpd_filter_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_accept && $past(deep_pd)) |-> ($past(cmd_op) == OP_RDP));
endmodule

// File: tb/test_flash_wr_guard.sv
module test_flash_wr_guard;
    localparam int AW  = 24;
    localparam int CW  = 16;
    localparam int PUW = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_op = '0;
    logic [CW-1:0] cmd_bits = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [7:0]    cmd_data = '0;
    logic          wp_n = 1'b1;
    logic          quad_mode = 1'b0;
    logic          cmd_accept, cmd_reject, wel, srwd, deep_pd, ready;
    logic [3:0]    bp;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    flash_wr_guard #(.ADDR_W(AW), .CNT_W(CW), .PUW_CYCLES(PUW)) i_flash_wr_guard (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bits(cmd_bits), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .wp_n(wp_n), .quad_mode(quad_mode), .cmd_accept(cmd_accept),
        .cmd_reject(cmd_reject), .wel(wel), .bp(bp), .srwd(srwd),
        .deep_pd(deep_pd), .ready(ready));

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Top 2^(AW-k) bytes protected, k = 15 - level.
    function automatic bit exp_prot(input int level, input longint addr);
        longint size = longint'(1) << AW;
        if (level == 0) return 1'b0;
        return addr >= size - (size >> (15 - level));
    endfunction

    // Send one frame and check the outcome strobe one clock later.
    task automatic send(input string req, input logic [7:0] op, input int bits,
                        input longint addr, input logic [7:0] data, input bit exp_ok);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_bits = CW'(bits);
        cmd_addr = AW'(addr); cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk({req, " accept"}, int'(cmd_accept), int'(exp_ok));
        chk({req, " reject"}, int'(cmd_reject), int'(!exp_ok));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 wel", int'(wel), 0);
        chk("R1 bp", int'(bp), 0);
        chk("R1 srwd", int'(srwd), 0);
        chk("R1 dpd", int'(deep_pd), 0);
        chk("R1 ready", int'(ready), 0);
        chk("R1 strobes", int'(cmd_accept | cmd_reject), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_lockout();
        send("R5 wren early", 8'h06, 8, 0, 0, 1'b1);
        chk("R5 wel set", int'(wel), 1);
        send("R2 wrsr in lockout", 8'h01, 16, 0, 8'h0C, 1'b0);
        chk("R2 bp kept", int'(bp), 0);
        chk("R6 wel kept", int'(wel), 1);
        chk("R2 not ready", int'(ready), 0);
        repeat (PUW) @(negedge clk);
        chk("R2 ready", int'(ready), 1);
        @(negedge clk);
        chk("R3 idle", int'(cmd_accept | cmd_reject), 0);
    endtask

    task automatic t_frame();
        send("R4 wrsr 15 bits", 8'h01, 15, 0, 8'h0C, 1'b0);
        chk("R4 bp kept", int'(bp), 0);
        send("R4 zero bits", 8'h01, 0, 0, 8'h0C, 1'b0);
        send("R4 wrdi 12 bits", 8'h04, 12, 0, 0, 1'b0);
        chk("R4 wel kept", int'(wel), 1);
    endtask

    task automatic t_wel();
        send("R5 wrdi", 8'h04, 8, 0, 0, 1'b1);
        chk("R5 wel clr", int'(wel), 0);
        send("R6 pp no wel", 8'h02, 40, 0, 0, 1'b0);
        send("R5 wren", 8'h06, 8, 0, 0, 1'b1);
        send("R6 pp", 8'h02, 40, 0, 0, 1'b1);
        chk("R6 wel clr after pp", int'(wel), 0);
    endtask

    task automatic t_wrsr();
        send("R5 wren", 8'h06, 8, 0, 0, 1'b1);
        send("R7 wrsr", 8'h01, 16, 0, 8'hB8, 1'b1);
        chk("R7 srwd", int'(srwd), 1);
        chk("R7 bp", int'(bp), 14);
        chk("R6 wel clr after wrsr", int'(wel), 0);
    endtask

    task automatic t_protect();
        send("R5 wren", 8'h06, 8, 0, 0, 1'b1);
        send("R10 se top half", 8'h20, 32, 'h800000, 0, !exp_prot(14, 'h800000));
        chk("R6 wel kept", int'(wel), 1);
        send("R10 se low half", 8'h20, 32, 'h7FFFFF, 0, !exp_prot(14, 'h7FFFFF));
        chk("R6 wel clr", int'(wel), 0);
        send("R5 wren", 8'h06, 8, 0, 0, 1'b1);
        send("R10 be top", 8'hD8, 32, 'hFFFFFF, 0, 1'b0);
        send("R11 ce with bp", 8'hC7, 8, 0, 0, 1'b0);
        chk("R11 wel kept", int'(wel), 1);
    endtask

    task automatic t_hwp();
        wp_n = 1'b0;
        send("R8 wrsr locked", 8'h01, 16, 0, 8'h00, 1'b0);
        chk("R8 bp kept", int'(bp), 14);
        quad_mode = 1'b1;
        send("R8 wrsr quad", 8'h01, 16, 0, 8'h04, 1'b1);
        chk("R8 bp", int'(bp), 1);
        chk("R8 srwd", int'(srwd), 0);
        quad_mode = 1'b0;
        send("R5 wren", 8'h06, 8, 0, 0, 1'b1);
        send("R10 pp below", 8'h02, 40, 'hFFFBFF, 0, !exp_prot(1, 'hFFFBFF));
        send("R5 wren", 8'h06, 8, 0, 0, 1'b1);
        send("R10 pp edge", 8'h02, 40, 'hFFFC00, 0, !exp_prot(1, 'hFFFC00));
        send("R7 wrsr clear", 8'h01, 16, 0, 8'h00, 1'b1);
        chk("R7 bp zero", int'(bp), 0);
        send("R5 wren", 8'h06, 8, 0, 0, 1'b1);
        send("R11 ce", 8'h60, 8, 0, 0, 1'b1);
        wp_n = 1'b1;
    endtask

    task automatic t_dpd();
        send("R9 dp", 8'hB9, 8, 0, 0, 1'b1);
        chk("R9 dpd set", int'(deep_pd), 1);
        send("R9 wren in dpd", 8'h06, 8, 0, 0, 1'b0);
        chk("R9 wel", int'(wel), 0);
        send("R9 read in dpd", 8'h03, 32, 0, 0, 1'b0);
        send("R9 rdp", 8'hAB, 8, 0, 0, 1'b1);
        chk("R9 dpd clr", int'(deep_pd), 0);
        send("R9 wren after", 8'h06, 8, 0, 0, 1'b1);
    endtask

    initial begin
        t_reset();
        t_lockout();
        t_frame();
        t_wel();
        t_wrsr();
        t_protect();
        t_hwp();
        t_dpd();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule